// File: doc/BRIEF.md
# Paired-Single Lane Permutation Unit

This block performs the lane-rearrangement instructions of a 64-bit paired-single floating-point format. Each 64-bit operand holds two IEEE single-precision numbers. The upper single sits in bits 63:32 and the lower single sits in bits 31:0. The unit takes the decoded instruction word, two 64-bit source operands, a general-register value that steers alignment and an endianness flag. From these it forms a 64-bit result together with a write enable.

The unit supports these operations:
- the four lane pairings;
- packing two single-precision values into one pair;
- extracting either lane as a single-precision result;
- the variable-align operation, whose result depends on machine endianness.

The unit does no arithmetic and stores nothing. It only routes lanes. It also flags instructions that the current privilege state forbids, and it flags alignment values whose outcome is architecturally undefined. An optional output register, present by default, delays every result and flag by one clock.

Top module: `pairLaneUnit`

## Requirements
- R1: While `rst` is high at a rising clock edge, the registered outputs become zero: `result`, `writeEn`, `reservedFault` and `unpredictable` all read 0 after reset.
- R2: The instruction fields are major opcode in bits 31:26, format in bits 25:21 and function in bits 5:0. With major 010001 and format 10110, the four function codes select these pairings, written as {upper half, lower half}:
  - 101100 gives {A.lo, B.lo};
  - 101101 gives {A.lo, B.hi};
  - 101110 gives {A.hi, B.lo};
  - 101111 gives {A.hi, B.hi}.
- R3: Major 010001 with format 10000 and function 100110 packs the two sources as {A[31:0], B[31:0]}.
- R4: Major 010001 with format 10110 extracts one lane of A into result bits 31:0 and zeroes bits 63:32. Function 101000 extracts A.lo and function 100000 extracts A.hi.
- R5: Major 010011 with function 011110 is the align operation. When `alignOff[1:0]` is 0 and `alignOff[2]` is 0, the result is A unchanged.
- R6: In the align operation, when `alignOff[2:0]` is 100 and `bigEndian` is 1, the result is {A.lo, B.hi}.
- R7: In the align operation, when `alignOff[2:0]` is 100 and `bigEndian` is 0, the result is {B.lo, A.hi}.
- R8: In the align operation, when `alignOff[1:0]` is nonzero, `unpredictable` is raised, the result is A unchanged and `writeEn` is 1.
- R9: When `userMode` is 1 and both `statusWideEn` and `statusPairEn` are 0, a recognised operation raises `reservedFault`, holds `writeEn` low and forces the result to zero. If either status bit is 1, or `userMode` is 0, the operation completes normally.
- R10: When `instrValid` is low, or the opcode is not one listed in R2 to R7, `writeEn`, `reservedFault` and `unpredictable` are 0 and the result is zero.
- R11: With `REG_OUT`=1, every output reflects the inputs that were present at the previous rising clock edge.
- R12: Instruction bits 20:6 (the register-number fields) have no effect on the result of the pairing and pack operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instrValid | input | 1 | An instruction is presented this cycle |
| instr | input | 32 | Decoded instruction word |
| srcA | input | 64 | First paired-single source |
| srcB | input | 64 | Second paired-single source |
| alignOff | input | 32 | General-register value that steers the align operation |
| bigEndian | input | 1 | 1 selects big-endian align behaviour |
| userMode | input | 1 | Processor is in user mode |
| statusWideEn | input | 1 | Status enable for wide (64-bit) operations |
| statusPairEn | input | 1 | Status enable for paired-single operations |
| result | output | 64 | Rearranged 64-bit result |
| writeEn | output | 1 | Result is valid and may be written back |
| reservedFault | output | 1 | Reserved-instruction condition |
| unpredictable | output | 1 | Align value outside the defined range |

## Verification
With the default output register, every result and flag for an instruction is due exactly one rising edge after that instruction is presented. The bench therefore drives a new instruction on each falling edge. It first compares the outputs showing at that falling edge with the expectation queued one cycle earlier, and only then queues the expectation for the instruction it is driving. Idle cycles and reset cycles sit in the same queue, so an output that appears early or late mismatches on the neighbouring cycle.

// File: rtl/pairLanePkg.sv
package pairLanePkg;

  typedef enum logic [1:0] {
    LANE_A_LO = 2'd0,
    LANE_A_HI = 2'd1,
    LANE_B_LO = 2'd2,
    LANE_B_HI = 2'd3
  } laneSrcE;

  // Strobes from control to datapath; index 1 is the upper result lane.
  typedef struct packed {
    logic             enable;
    logic             clearHi;
    laneSrcE [1:0]    src;
  } laneCtrlT;

  localparam logic [5:0] MAJ_COP   = 6'b010001;
  localparam logic [5:0] MAJ_COPX  = 6'b010011;
  localparam logic [4:0] FMT_PAIR  = 5'b10110;
  localparam logic [4:0] FMT_SGL   = 5'b10000;
  localparam logic [5:0] FN_LOLO   = 6'b101100;
  localparam logic [5:0] FN_LOHI   = 6'b101101;
  localparam logic [5:0] FN_HILO   = 6'b101110;
  localparam logic [5:0] FN_HIHI   = 6'b101111;
  localparam logic [5:0] FN_PACK   = 6'b100110;
  localparam logic [5:0] FN_TAKELO = 6'b101000;
  localparam logic [5:0] FN_TAKEHI = 6'b100000;
  localparam logic [5:0] FN_ALIGN  = 6'b011110;

endpackage

// File: rtl/pairLaneCtrl.sv
module pairLaneCtrl
  import pairLanePkg::*;
#(
  parameter int GPR_W = 32
) (
  input  logic             instrValid,
  input  logic [31:0]      instr,
  input  logic [GPR_W-1:0] alignOff,
  input  logic             bigEndian,
  input  logic             userMode,
  input  logic             statusWideEn,
  input  logic             statusPairEn,
  output laneCtrlT         ctrl,
  output logic             writeEn,
  output logic             reservedFault,
  output logic             unpredictable
);

  logic [5:0] major;
  logic [4:0] fmt;
  logic [5:0] func;
  logic       known;
  logic       badAlign;
  logic       blocked;
  laneSrcE    hiSel;
  laneSrcE    loSel;
  logic       clearHi;
  logic       unusedBits;

  assign major = instr[31:26];
  assign fmt   = instr[25:21];
  assign func  = instr[5:0];
  assign unusedBits = ^{instr[20:6], alignOff[GPR_W-1:3]};

  always_comb begin
    known    = 1'b0;
    badAlign = 1'b0;
    clearHi  = 1'b0;
    hiSel    = LANE_A_HI;
    loSel    = LANE_A_LO;
    if (major == MAJ_COP && fmt == FMT_PAIR) begin
      case (func)
        FN_LOLO:   begin known = 1'b1; hiSel = LANE_A_LO; loSel = LANE_B_LO; end
        FN_LOHI:   begin known = 1'b1; hiSel = LANE_A_LO; loSel = LANE_B_HI; end
        FN_HILO:   begin known = 1'b1; hiSel = LANE_A_HI; loSel = LANE_B_LO; end
        FN_HIHI:   begin known = 1'b1; hiSel = LANE_A_HI; loSel = LANE_B_HI; end
        FN_TAKELO: begin known = 1'b1; clearHi = 1'b1; loSel = LANE_A_LO; end
        FN_TAKEHI: begin known = 1'b1; clearHi = 1'b1; loSel = LANE_A_HI; end
        default:   known = 1'b0;
      endcase
    end else if (major == MAJ_COP && fmt == FMT_SGL && func == FN_PACK) begin
      known = 1'b1;
      hiSel = LANE_A_LO;
      loSel = LANE_B_LO;
    end else if (major == MAJ_COPX && func == FN_ALIGN) begin
      known = 1'b1;
      if (alignOff[1:0] != 2'b00) begin
        badAlign = 1'b1;
      end else if (alignOff[2]) begin
        if (bigEndian) begin
          hiSel = LANE_A_LO;
          loSel = LANE_B_HI;
        end else begin
          hiSel = LANE_B_LO;
          loSel = LANE_A_HI;
        end
      end
    end
  end

  assign blocked       = userMode && !statusWideEn && !statusPairEn;
  assign writeEn       = instrValid && known && !blocked;
  assign reservedFault = instrValid && known && blocked;
  assign unpredictable = writeEn && badAlign;

  assign ctrl.enable  = writeEn;
  assign ctrl.clearHi = clearHi;
  assign ctrl.src[1]  = hiSel;
  assign ctrl.src[0]  = loSel;

endmodule

// File: rtl/pairLaneDatapath.sv
module pairLaneDatapath
  import pairLanePkg::*;
#(
  parameter int LANE_W = 32,
  localparam int DATA_W = 2 * LANE_W
) (
  input  laneCtrlT          ctrl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result
);

  function automatic logic [LANE_W-1:0] pickLane(
    input laneSrcE           sel,
    input logic [DATA_W-1:0] a,
    input logic [DATA_W-1:0] b
  );
    case (sel)
      LANE_A_LO: pickLane = a[LANE_W-1:0];
      LANE_A_HI: pickLane = a[DATA_W-1:LANE_W];
      LANE_B_LO: pickLane = b[LANE_W-1:0];
      default:   pickLane = b[DATA_W-1:LANE_W];
    endcase
  endfunction

  for (genvar g = 0; g < 2; g++) begin : gLane
    logic keep;
    if (g == 1) begin : gUpper
      assign keep = ctrl.enable && !ctrl.clearHi;
    end else begin : gLower
      assign keep = ctrl.enable;
    end
    assign result[g*LANE_W +: LANE_W] =
      keep ? pickLane(ctrl.src[g], srcA, srcB) : '0;
  end

endmodule

// File: rtl/pairLaneUnit.sv
module pairLaneUnit
  import pairLanePkg::*;
#(
  parameter int LANE_W  = 32,
  parameter int GPR_W   = 32,
  parameter bit REG_OUT = 1'b1,
  localparam int DATA_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instrValid,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [GPR_W-1:0]  alignOff,
  input  logic              bigEndian,
  input  logic              userMode,
  input  logic              statusWideEn,
  input  logic              statusPairEn,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic              reservedFault,
  output logic              unpredictable
);

  laneCtrlT          ctrl;
  logic [DATA_W-1:0] resultNext;
  logic              weNext;
  logic              rfNext;
  logic              upNext;

  pairLaneCtrl #(.GPR_W(GPR_W)) uCtrl (
    .instrValid    (instrValid),
    .instr         (instr),
    .alignOff      (alignOff),
    .bigEndian     (bigEndian),
    .userMode      (userMode),
    .statusWideEn  (statusWideEn),
    .statusPairEn  (statusPairEn),
    .ctrl          (ctrl),
    .writeEn       (weNext),
    .reservedFault (rfNext),
    .unpredictable (upNext)
  );

  pairLaneDatapath #(.LANE_W(LANE_W)) uPath (
    .ctrl   (ctrl),
    .srcA   (srcA),
    .srcB   (srcB),
    .result (resultNext)
  );

  if (REG_OUT) begin : gReg
    always_ff @(posedge clk) begin
      if (rst) begin
        result        <= '0;
        writeEn       <= 1'b0;
        reservedFault <= 1'b0;
        unpredictable <= 1'b0;
      end else begin
        result        <= resultNext;
        writeEn       <= weNext;
        reservedFault <= rfNext;
        unpredictable <= upNext;
      end
    end
  end else begin : gComb
    logic unusedClk;
    assign unusedClk     = clk ^ rst;
    assign result        = resultNext;
    assign writeEn       = weNext;
    assign reservedFault = rfNext;
    assign unpredictable = upNext;
  end

endmodule

// File: rtl/pairLaneChecker.sv
module pairLaneChecker #(
  parameter int DATA_W  = 64,
  parameter bit REG_OUT = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              instrValid,
  input logic              userMode,
  input logic              statusWideEn,
  input logic              statusPairEn,
  input logic [DATA_W-1:0] result,
  input logic              writeEn,
  input logic              reservedFault,
  input logic              unpredictable
);

  assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    reservedFault |-> (!writeEn && result == '0));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({reservedFault, unpredictable}));

  assert_unpred_writes_R8: assert property (@(posedge clk) disable iff (rst)
    unpredictable |-> writeEn);

  assert_no_write_zero_R10: assert property (@(posedge clk) disable iff (rst)
    !writeEn |-> result == '0);

  if (REG_OUT) begin : gTimed
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
      !instrValid |=> (!writeEn && !reservedFault && !unpredictable));

    assert_blocked_nowrite_R9: assert property (@(posedge clk) disable iff (rst)
      (instrValid && userMode && !statusWideEn && !statusPairEn) |=> !writeEn);
  end

endmodule

bind pairLaneUnit pairLaneChecker #(.DATA_W(2 * LANE_W), .REG_OUT(REG_OUT)) uChk (
  .clk           (clk),
  .rst           (rst),
  .instrValid    (instrValid),
  .userMode      (userMode),
  .statusWideEn  (statusWideEn),
  .statusPairEn  (statusPairEn),
  .result        (result),
  .writeEn       (writeEn),
  .reservedFault (reservedFault),
  .unpredictable (unpredictable)
);

// File: tb/tb_pairLaneUnit.sv
`timescale 1ns/1ps
module tb_pairLaneUnit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        instrValid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic [31:0] alignOff = '0;
  logic        bigEndian = 1'b0;
  logic        userMode = 1'b0;
  logic        statusWideEn = 1'b0;
  logic        statusPairEn = 1'b0;
  logic [63:0] result;
  logic        writeEn;
  logic        reservedFault;
  logic        unpredictable;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [63:0] expRes[$];
  logic [2:0]  expFlg[$];
  string       expTag[$];

  always #2 clk = ~clk;

  pairLaneUnit dut (
    .clk(clk), .rst(rst), .instrValid(instrValid), .instr(instr),
    .srcA(srcA), .srcB(srcB), .alignOff(alignOff), .bigEndian(bigEndian),
    .userMode(userMode), .statusWideEn(statusWideEn), .statusPairEn(statusPairEn),
    .result(result), .writeEn(writeEn), .reservedFault(reservedFault),
    .unpredictable(unpredictable)
  );

  function automatic logic [31:0] mk(input logic [5:0] maj, input logic [4:0] fm,
                                     input logic [14:0] regs, input logic [5:0] fn);
    return {maj, fm, regs, fn};
  endfunction

  // Behavioural expectation: flags are {writeEn, reservedFault, unpredictable}.
  task automatic model(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b,
                       input logic [31:0] g, input logic be, input logic u,
                       input logic wx, input logic px, input logic v,
                       output logic [63:0] r, output logic [2:0] f, output string t);
    logic hit = 1'b0;
    logic odd = 1'b0;
    logic [63:0] val = '0;
    string what = "R10";
    if (ins[31:26] == 6'b010001 && ins[25:21] == 5'b10110) begin
      hit = 1'b1;
      case (ins[5:0])
        6'b101100: begin val = {a[31:0],  b[31:0]};  what = "R2"; end
        6'b101101: begin val = {a[31:0],  b[63:32]}; what = "R2"; end
        6'b101110: begin val = {a[63:32], b[31:0]};  what = "R2"; end
        6'b101111: begin val = {a[63:32], b[63:32]}; what = "R2"; end
        6'b101000: begin val = {32'h0, a[31:0]};     what = "R4"; end
        6'b100000: begin val = {32'h0, a[63:32]};    what = "R4"; end
        default:   hit = 1'b0;
      endcase
    end else if (ins[31:26] == 6'b010001 && ins[25:21] == 5'b10000 && ins[5:0] == 6'b100110) begin
      hit = 1'b1; val = {a[31:0], b[31:0]}; what = "R3";
    end else if (ins[31:26] == 6'b010011 && ins[5:0] == 6'b011110) begin
      hit = 1'b1;
      if (g[1:0] != 0) begin odd = 1'b1; val = a; what = "R8"; end
      else if (!g[2]) begin val = a; what = "R5"; end
      else if (be) begin val = {a[31:0], b[63:32]}; what = "R6"; end
      else begin val = {b[31:0], a[63:32]}; what = "R7"; end
    end
    if (!v || !hit) begin
      r = '0; f = 3'b000; t = "R10";
    end else if (u && !wx && !px) begin
      r = '0; f = 3'b010; t = "R9";
    end else begin
      r = val; f = {1'b1, 1'b0, odd}; t = u ? "R9" : what;
    end
  endtask

  // Compare outputs from last cycle's stimulus (one-cycle latency, R11), then drive anew.
  task automatic step(input logic [31:0] ins, input logic [63:0] a, input logic [63:0] b,
                      input logic [31:0] g, input logic be, input logic u,
                      input logic wx, input logic px, input logic v);
    logic [63:0] r;
    logic [2:0]  f;
    string       t;
    @(negedge clk);
    if (expRes.size() > 0) begin
      logic [63:0] er = expRes.pop_front();
      logic [2:0]  ef = expFlg.pop_front();
      string       et = expTag.pop_front();
      total++;
      if (result !== er || {writeEn, reservedFault, unpredictable} !== ef) begin
        bad++;
        $display("FAIL %s (R11 timing) result=%h flags=%b expected result=%h flags=%b",
                 et, result, {writeEn, reservedFault, unpredictable}, er, ef);
      end
    end
    instr = ins; srcA = a; srcB = b; alignOff = g; bigEndian = be;
    userMode = u; statusWideEn = wx; statusPairEn = px; instrValid = v;
    model(ins, a, b, g, be, u, wx, px, v, r, f, t);
    expRes.push_back(r); expFlg.push_back(f); expTag.push_back(t);
  endtask

  localparam logic [63:0] A0 = 64'h3F80_0000_C020_0000;
  localparam logic [63:0] B0 = 64'h4110_0000_BE80_0000;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (result !== '0 || {writeEn, reservedFault, unpredictable} !== 3'b000) begin
      bad++;
      $display("FAIL R1 result=%h flags=%b expected result=0 flags=000",
               result, {writeEn, reservedFault, unpredictable});
    end
    rst = 1'b0;
    // R2 pairings
    step(mk(6'b010001, 5'b10110, 15'h1234, 6'b101100), A0, B0, 0, 0, 0, 0, 0, 1);
    step(mk(6'b010001, 5'b10110, 15'h1234, 6'b101101), A0, B0, 0, 0, 0, 0, 0, 1);
    step(mk(6'b010001, 5'b10110, 15'h1234, 6'b101110), A0, B0, 0, 0, 0, 0, 0, 1);
    step(mk(6'b010001, 5'b10110, 15'h1234, 6'b101111), A0, B0, 0, 0, 0, 0, 0, 1);
    // R12 other register fields, same result expected
    step(mk(6'b010001, 5'b10110, 15'h7FFF, 6'b101101), A0, B0, 0, 0, 0, 0, 0, 1);
    step(mk(6'b010001, 5'b10000, 15'h0000, 6'b100110), A0, B0, 0, 0, 0, 0, 0, 1);
    // R3 pack
    step(mk(6'b010001, 5'b10000, 15'h0A0B, 6'b100110), B0, A0, 0, 0, 0, 0, 0, 1);
    // R4 extracts
    step(mk(6'b010001, 5'b10110, 15'h0040, 6'b101000), A0, B0, 0, 0, 0, 0, 0, 1);
    step(mk(6'b010001, 5'b10110, 15'h0040, 6'b100000), A0, B0, 0, 0, 0, 0, 0, 1);
    // R5 to R8 align
    step(mk(6'b010011, 5'b00001, 15'h2222, 6'b011110), A0, B0, 32'h0, 1, 0, 0, 0, 1);
    step(mk(6'b010011, 5'b00001, 15'h2222, 6'b011110), A0, B0, 32'hF0, 0, 0, 0, 0, 1);
    step(mk(6'b010011, 5'b00001, 15'h2222, 6'b011110), A0, B0, 32'h4, 1, 0, 0, 0, 1);
    step(mk(6'b010011, 5'b00001, 15'h2222, 6'b011110), A0, B0, 32'h4, 0, 0, 0, 0, 1);
    step(mk(6'b010011, 5'b00001, 15'h2222, 6'b011110), A0, B0, 32'h1, 1, 0, 0, 0, 1);
    step(mk(6'b010011, 5'b00001, 15'h2222, 6'b011110), A0, B0, 32'h6, 0, 0, 0, 0, 1);
    step(mk(6'b010011, 5'b00001, 15'h2222, 6'b011110), A0, B0, 32'h3, 1, 0, 0, 0, 1);
    // R9 privilege
    step(mk(6'b010001, 5'b10110, 15'h1234, 6'b101111), A0, B0, 0, 0, 1, 0, 0, 1);
    step(mk(6'b010011, 5'b00001, 15'h2222, 6'b011110), A0, B0, 32'h4, 1, 1, 0, 0, 1);
    step(mk(6'b010001, 5'b10110, 15'h1234, 6'b101111), A0, B0, 0, 0, 1, 1, 0, 1);
    step(mk(6'b010001, 5'b10110, 15'h1234, 6'b101100), A0, B0, 0, 0, 1, 0, 1, 1);
    // R10 unrecognised and idle
    step(mk(6'b010001, 5'b10110, 15'h1234, 6'b000000), A0, B0, 0, 0, 0, 0, 0, 1);
    step(mk(6'b010001, 5'b10000, 15'h1234, 6'b101100), A0, B0, 0, 0, 0, 0, 0, 1);
    step(mk(6'b010001, 5'b10110, 15'h1234, 6'b101100), A0, B0, 0, 0, 0, 0, 0, 0);
    step(32'hFFFF_FFFF, A0, B0, 0, 0, 0, 0, 0, 1);
    // Mixed stream, back to back
    for (int i = 0; i < 200; i++) begin
      logic [5:0]  fns[8] = '{6'b101100, 6'b101101, 6'b101110, 6'b101111,
                              6'b101000, 6'b100000, 6'b100110, 6'b011110};
      logic [5:0]  fn = fns[$urandom_range(0, 7)];
      logic [5:0]  maj = (fn == 6'b011110) ? 6'b010011 : 6'b010001;
      logic [4:0]  fm = (fn == 6'b100110) ? 5'b10000 : 5'b10110;
      logic [31:0] ins = mk(maj, fm, 15'($urandom), fn);
      if (($urandom & 15) == 0) ins = $urandom;
      step(ins, {$urandom, $urandom}, {$urandom, $urandom}, $urandom_range(0, 7),
           1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), ($urandom & 7) != 0);
    end
    step('0, '0, '0, 0, 0, 0, 0, 0, 0);
    step('0, '0, '0, 0, 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule